// File: doc/BRIEF.md
# Hardware Cursor Overlay with Fine Bit Positioning

This block lays a 32×32 one-bit cursor over a single channel's video stream. Video arrives four pixels at a time as a nibble, and one nibble is handled per clock. A 256×4 pattern store holds the cursor picture as 32 segments, and each segment is one cursor row of eight nibbles. Software loads the store through its own write port at any time.

For each scan line, software writes a control word during the line before. The word gives the segment to draw, an enable, and a position. The position splits into a coarse nibble count and a two-bit fine shift. On every control-phase cycle the word moves into an active copy, and the coarse count is preset into a position counter. During the visible part of the line the counter steps once per nibble. The eight pattern nibbles of the chosen segment are emitted while the upper five bits of the counter are zero. Each emitted nibble is delayed by the fine shift. Bits that spill past the nibble edge are carried into the next nibble, which can add a ninth nibble after the last one. The cursor nibble is ORed into the video. The background polarity is then applied, and one output register adds a single nibble of latency.

A small state machine tracks where the line is relative to the cursor. It has four states. DONE is the reset state and holds while no cursor is pending. SEEK counts toward the cursor window. SHOW emits pattern nibbles. DRAIN emits the spilled bits. These are the transitions:
- Any control-phase cycle moves to SEEK if the loaded enable is 1, and to DONE otherwise.
- SEEK moves to SHOW when the window opens on a nibble index below 7.
- SEEK moves straight to DRAIN when the window opens on index 7.
- SHOW moves to DRAIN after index 7.
- DRAIN always moves to DONE.
- DONE holds until the next control phase.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held and on the first cycle after it, `vid_out` is 0. No cursor appears until a control phase has loaded a word with the enable set.
- R2: When `pat_we` is 1, `pat_wdata` is written to pattern address `pat_addr` at the clock edge. Address bits [7:3] are the segment and bits [2:0] are the nibble index within the row. A read of an address in the same cycle as a write to it returns the old contents.
- R3: The control word is laid out as follows: bits [4:0] are the segment, bit [5] is the enable, bits [7:6] are the fine shift, and bits [15:8] are the coarse start count. A write with `ctl_wr` is only held. It takes effect on the next cycle with `ctrl_phase` = 1, and a write in the same cycle as a control-phase cycle is not seen until the following control phase. A write during a visible line does not change that line.
- R4: Each control-phase cycle presets the position counter from bits [15:8], and each cycle with `ctrl_phase` = 0 adds 1 to it, modulo 256. A pattern nibble is emitted in each visible cycle where counter bits [7:3] are 0, and the nibble index is counter bits [2:0]. At most one window of up to eight nibbles occurs per line, even if the counter wraps.
- R5: If the loaded enable bit is 0, the cursor adds nothing for the whole line.
- R6: With fine shift s, pattern bit b of an emitted nibble appears at cursor bit b+s. Pattern bits with b+s ≥ 4 appear at bit b+s−4 of the next cycle's cursor nibble. This holds for the cycle after the last emitted nibble too.
- R7: Bit 0 of a nibble is the first pixel. The cursor nibble is ORed with `vid_in`. When `bg_pol` is 0 the result is inverted, and when it is 1 it passes unchanged.
- R8: `vid_out` shows, one clock later, the mix of the `vid_in`, `bg_pol` and cursor nibble of the previous cycle.
- R9: During `ctrl_phase` = 1 the cursor nibble is 0, and any spilled bits still pending are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Store `ctl_word` in the holding register |
| ctl_word | input | 16 | Per-line cursor control word |
| ctrl_phase | input | 1 | High during the line's control (blanking) segment |
| pat_we | input | 1 | Pattern store write enable |
| pat_addr | input | 8 | Pattern store write address |
| pat_wdata | input | 4 | Pattern nibble to write |
| vid_in | input | 4 | Video nibble from the line buffer |
| bg_pol | input | 1 | Background polarity select |
| vid_out | output | 4 | Mixed video nibble to the line driver |

## Verification
Two of the block's functions can fall in the same cycle.

The first case is a pattern store write and a display read of the same address. The bench writes a new value to the row nibble that the window is reading in that very cycle. The output must carry the old nibble. The following line must then show the new nibble at the same place.

The second case is a control word write and a control-phase load in the same cycle. The bench issues the write on a control-phase cycle. That line must be drawn from the previously held word.

A behavioural model in the bench predicts every output nibble, so both collisions are judged on each clock.

// File: rtl/curs_ovl_pkg.sv
package curs_ovl_pkg;
    typedef enum logic [1:0] {
        ST_DONE  = 2'd0,
        ST_SEEK  = 2'd1,
        ST_SHOW  = 2'd2,
        ST_DRAIN = 2'd3
    } curs_state_e;
endpackage

// File: rtl/cursor_pattern_store.sv
module cursor_pattern_store #(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [NIB_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [NIB_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [NIB_W-1:0] mem [DEPTH];

    // write at the edge; the read below sees contents before the edge
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cursor_seek_fsm.sv
module cursor_seek_fsm
    import curs_ovl_pkg::*;
#(
    parameter int SEG_W = 5,
    parameter int IDX_W = 3,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_phase,
    input  logic                   ld_en,
    input  logic [SEG_W-1:0]       ld_seg,
    input  logic [CNT_W-1:0]       ld_cnt,
    output logic                   emit,
    output logic                   drain,
    output logic                   act_en,
    output logic [SEG_W+IDX_W-1:0] rd_addr
);
    localparam int SEG_NIBS = 1 << IDX_W;
    localparam int EC_W     = IDX_W + 2;

    curs_state_e      state, state_nx;
    logic [CNT_W-1:0] pos_cnt;
    logic [SEG_W-1:0] act_seg;
    logic             in_win;
    logic             last_nib;

    assign in_win   = (pos_cnt[CNT_W-1:IDX_W] == '0);
    assign last_nib = (pos_cnt[IDX_W-1:0] == '1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DONE;
        end else begin
            state <= state_nx;
        end
    end

    // position counter and active copy of the control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_cnt <= '0;
            act_seg <= '0;
            act_en  <= 1'b0;
        end else if (ctrl_phase) begin
            pos_cnt <= ld_cnt;
            act_seg <= ld_seg;
            act_en  <= ld_en;
        end else begin
            pos_cnt <= pos_cnt + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        if (ctrl_phase) begin
            state_nx = ld_en ? ST_SEEK : ST_DONE;
        end else begin
            unique case (state)
                ST_SEEK:  if (in_win) state_nx = last_nib ? ST_DRAIN : ST_SHOW;
                ST_SHOW:  if (last_nib) state_nx = ST_DRAIN;
                ST_DRAIN: state_nx = ST_DONE;
                ST_DONE:  state_nx = ST_DONE;
                default:  state_nx = ST_DONE;
            endcase
        end
    end

    // outputs
    always_comb begin
        emit  = 1'b0;
        drain = 1'b0;
        if (!ctrl_phase) begin
            unique case (state)
                ST_SEEK:  emit  = in_win;
                ST_SHOW:  emit  = 1'b1;
                ST_DRAIN: drain = 1'b1;
                ST_DONE:  emit  = 1'b0;
                default:  emit  = 1'b0;
            endcase
        end
    end

    assign rd_addr = {act_seg, pos_cnt[IDX_W-1:0]};

    // emissions since the last control phase, used only by the checks
    logic [EC_W-1:0] emit_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_phase) begin
            emit_cnt <= '0;
        end else if (emit && emit_cnt != '1) begin
            emit_cnt <= emit_cnt + 1'b1;
        end
    end

    // R4: no line ever emits more than one row of nibbles
    assert_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        emit_cnt <= EC_W'(SEG_NIBS));

    // R4: once showing, the counter stays inside the window
    assert_show_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHOW && !ctrl_phase) |-> in_win);

    // R5: a disabled line never reads the pattern store
    assert_disabled_no_emit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |-> !emit);
endmodule

// File: rtl/cursor_fine_shift.sv
module cursor_fine_shift #(
    parameter int NIB_W = 4,
    parameter int SH_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             emit,
    input  logic             drain,
    input  logic [NIB_W-1:0] pat,
    input  logic [SH_W-1:0]  shift,
    output logic [NIB_W-1:0] cur
);
    logic [2*NIB_W-1:0] wide;
    logic [NIB_W-1:0]   carry;

    assign wide = {{NIB_W{1'b0}}, pat} << shift;

    always_comb begin
        cur = '0;
        if (!clear) begin
            if (emit) begin
                cur = wide[NIB_W-1:0] | carry;
            end else if (drain) begin
                cur = carry;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            carry <= '0;
        end else begin
            carry <= emit ? wide[2*NIB_W-1:NIB_W] : '0;
        end
    end

    // R6: spilled bits can only exist when a non-zero shift is active
    assert_carry_needs_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (carry != '0) |-> (shift != '0));

    // R9: nothing is emitted while the control phase is active
    assert_ctrl_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> (cur == '0));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
    parameter int NIB_W = 4,
    parameter int SEG_W = 5,
    parameter int IDX_W = 3,
    parameter int POS_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_wr,
    input  logic [SEG_W+POS_W:0]          ctl_word,
    input  logic                          ctrl_phase,
    input  logic                          pat_we,
    input  logic [SEG_W+IDX_W-1:0]        pat_addr,
    input  logic [NIB_W-1:0]              pat_wdata,
    input  logic [NIB_W-1:0]              vid_in,
    input  logic                          bg_pol,
    output logic [NIB_W-1:0]              vid_out
);
    localparam int SH_W   = $clog2(NIB_W);
    localparam int CNT_W  = POS_W - SH_W;
    localparam int ADDR_W = SEG_W + IDX_W;
    localparam int CW     = SEG_W + 1 + POS_W;
    localparam int EN_BIT = SEG_W;
    localparam int SH_LSB = SEG_W + 1;

    logic [CW-1:0]     hold_word;
    logic [SH_W-1:0]   act_shift;
    logic              emit, drain, act_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [NIB_W-1:0]  pat_rd;
    logic [NIB_W-1:0]  cur_nib;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
        end else if (ctl_wr) begin
            hold_word <= ctl_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_shift <= '0;
        end else if (ctrl_phase) begin
            act_shift <= hold_word[SH_LSB +: SH_W];
        end
    end

    cursor_pattern_store #(.NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (pat_we),
        .waddr (pat_addr),
        .wdata (pat_wdata),
        .raddr (rd_addr),
        .rdata (pat_rd)
    );

    cursor_seek_fsm #(.SEG_W(SEG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_seek (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_phase (ctrl_phase),
        .ld_en      (hold_word[EN_BIT]),
        .ld_seg     (hold_word[SEG_W-1:0]),
        .ld_cnt     (hold_word[CW-1 -: CNT_W]),
        .emit       (emit),
        .drain      (drain),
        .act_en     (act_en),
        .rd_addr    (rd_addr)
    );

    cursor_fine_shift #(.NIB_W(NIB_W), .SH_W(SH_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctrl_phase),
        .emit  (emit),
        .drain (drain),
        .pat   (pat_rd),
        .shift (act_shift),
        .cur   (cur_nib)
    );

    // mixing stage: OR before polarity, one nibble of latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_out <= '0;
        end else begin
            vid_out <= (vid_in | cur_nib) ^ {NIB_W{~bg_pol}};
        end
    end

    // R5: a line loaded with the enable clear contributes no cursor bits
    assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |-> (cur_nib == '0));

    // R1: the output holds 0 on the first cycle after reset
    assert_reset_out_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (vid_out == '0));
endmodule

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [15:0] ctl_word = '0;
    logic       ctrl_phase = 1'b0;
    logic       pat_we = 1'b0;
    logic [7:0] pat_addr = '0;
    logic [3:0] pat_wdata = '0;
    logic [3:0] vid_in = '0;
    logic       bg_pol = 1'b1;
    logic [3:0] vid_out;

    int n_cmp = 0;
    int n_bad = 0;
    string req = "R1";

    // behavioural model state
    int hold = 0, a_seg = 0, a_en = 0, a_sh = 0, cnt = 0, carry = 0;
    bit done = 1'b1;
    int ram [256];

    always #10 clk = ~clk;

    cursor_overlay uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
        .ctrl_phase(ctrl_phase), .pat_we(pat_we), .pat_addr(pat_addr),
        .pat_wdata(pat_wdata), .vid_in(vid_in), .bg_pol(bg_pol), .vid_out(vid_out)
    );

    task automatic check(input int exp, input string r);
        n_cmp++;
        if (vid_out !== exp[3:0]) begin
            n_bad++;
            $display("FAIL %s: vid_out=%h expected=%h at %0t", r, vid_out, exp[3:0], $time);
        end
    endtask

    // one nibble: predict, clock, compare
    task automatic step();
        int cur, w, e;
        cur = 0;
        if (ctrl_phase) begin
            a_seg = hold & 31; a_en = (hold >> 5) & 1;
            a_sh = (hold >> 6) & 3; cnt = (hold >> 8) & 255;
            done = (a_en == 0); carry = 0;
        end else begin
            if (!done && cnt < 8) begin
                w = ram[a_seg*8 + cnt] << a_sh;
                cur = (w & 15) | carry;
                carry = (w >> 4) & 15;
                if (cnt == 7) done = 1'b1;
            end else begin
                cur = carry; carry = 0;
            end
            cnt = (cnt + 1) % 256;
        end
        e = (int'(vid_in) | cur) ^ (bg_pol ? 0 : 15);
        if (ctl_wr) hold = int'(ctl_word);
        if (pat_we) ram[pat_addr] = int'(pat_wdata);
        @(posedge clk); #1;
        check(e, req);
    endtask

    task automatic idle_inputs();
        ctl_wr = 1'b0; pat_we = 1'b0; ctrl_phase = 1'b0; vid_in = '0;
    endtask

    function automatic logic [15:0] word(int seg, int en, int sh, int start);
        return 16'((start << 8) | (sh << 6) | (en << 5) | seg);
    endfunction

    // hold a word, run a control phase, then nact visible nibbles
    task automatic run_line(input logic [15:0] cw, input int nact, input int vmode,
                            input bit pol, input string r);
        req = r;
        bg_pol = pol;
        ctl_wr = 1'b1; ctl_word = cw; step(); ctl_wr = 1'b0;
        ctrl_phase = 1'b1;
        for (int i = 0; i < 3; i++) step();
        ctrl_phase = 1'b0;
        for (int i = 0; i < nact; i++) begin
            vid_in = (vmode == 0) ? 4'h0 : 4'((i * 5 + vmode) & 15);
            step();
        end
        vid_in = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        check(0, "R1");             // R1 during reset
        rst_n = 1'b1;
        req = "R1";
        step();                     // R1 first cycle after reset

        // R2 fill the pattern store; R1 no cursor shown meanwhile
        req = "R2";
        for (int a = 0; a < 256; a++) begin
            pat_we = 1'b1; pat_addr = 8'(a); pat_wdata = 4'((a * 7 + 3) & 15);
            vid_in = 4'(a & 15);
            step();
        end
        idle_inputs();

        run_line(word(3, 1, 0, 251), 20, 0, 1'b1, "R4");   // window at nibble 5
        run_line(word(6, 1, 1, 250), 20, 2, 1'b1, "R6");   // shift 1
        run_line(word(17, 1, 2, 252), 20, 0, 1'b1, "R6");  // shift 2
        run_line(word(31, 1, 3, 254), 20, 7, 1'b1, "R6");  // shift 3, ninth nibble
        run_line(word(12, 1, 0, 253), 20, 1, 1'b0, "R7");  // inverted background
        run_line(word(20, 1, 3, 252), 20, 9, 1'b0, "R7");
        run_line(word(5, 0, 1, 252), 20, 3, 1'b1, "R5");   // disabled line
        run_line(word(8, 1, 2, 3), 20, 0, 1'b1, "R4");     // starts mid-row
        run_line(word(0, 1, 1, 0), 270, 4, 1'b1, "R4");    // wrap: one window only
        run_line(word(2, 1, 0, 255), 12, 5, 1'b1, "R8");

        // R3: a word written during a visible line leaves that line alone
        req = "R3";
        bg_pol = 1'b1;
        ctl_wr = 1'b1; ctl_word = word(11, 1, 0, 250); step(); ctl_wr = 1'b0;
        ctrl_phase = 1'b1; step(); step(); ctrl_phase = 1'b0;
        for (int i = 0; i < 16; i++) begin
            ctl_wr = (i == 3); ctl_word = word(1, 0, 0, 250);
            step();
        end
        ctl_wr = 1'b0;

        // R3: write landing on a control-phase cycle is seen one phase later
        ctrl_phase = 1'b1;
        ctl_wr = 1'b1; ctl_word = word(22, 1, 2, 252); step(); ctl_wr = 1'b0;
        ctrl_phase = 1'b0;
        for (int i = 0; i < 14; i++) step();   // still disabled word
        ctrl_phase = 1'b1; step(); ctrl_phase = 1'b0;
        for (int i = 0; i < 14; i++) step();   // now segment 22

        // R2 collision: write the nibble being displayed this very cycle
        req = "R2";
        ctl_wr = 1'b1; ctl_word = word(9, 1, 0, 254); step(); ctl_wr = 1'b0;
        ctrl_phase = 1'b1; step(); ctrl_phase = 1'b0;
        for (int i = 0; i < 14; i++) begin
            pat_we = (i == 4); pat_addr = 8'(9 * 8 + 2); pat_wdata = 4'hF;
            step();
        end
        pat_we = 1'b0;
        ctrl_phase = 1'b1; step(); ctrl_phase = 1'b0;
        for (int i = 0; i < 14; i++) step();    // new value now shown

        // R9: control phase cuts a window holding spilled bits
        req = "R9";
        ctl_wr = 1'b1; ctl_word = word(30, 1, 3, 254); step(); ctl_wr = 1'b0;
        ctrl_phase = 1'b1; step(); ctrl_phase = 1'b0;
        for (int i = 0; i < 5; i++) step();
        ctrl_phase = 1'b1; vid_in = 4'h6;
        step(); step();
        ctrl_phase = 1'b0; vid_in = '0;
        ctl_wr = 1'b1; ctl_word = word(30, 0, 3, 254); step(); ctl_wr = 1'b0;
        ctrl_phase = 1'b1; step(); ctrl_phase = 1'b0;
        for (int i = 0; i < 6; i++) step();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule